// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control for a successive-approximation converter. Software reaches it through two small registers. The control byte holds an enable, a start bit, an auto-trigger enable, a completion flag, an interrupt enable and a 3-bit prescaler code. The source register holds a 4-bit channel select and a free-running select. The block divides the system clock into a conversion clock and opens a busy window for each conversion. It latches the channel when a conversion starts. When the conversion ends it loads the 10-bit sample from the analog side, sets the completion flag and raises an interrupt request.

Several controls take effect only at conversion boundaries. A disable, a channel change or a prescaler change written during a conversion waits until that conversion ends. The first conversion after enabling also initializes the converter, so it runs longer than later ones. Conversions start in one of three ways: a start-bit write, a rising edge on an external trigger, or a free-running restart that follows each completed conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control byte reads 0, the source register reads 0, and result, busy, conv_clk and irq are all 0.
- R2: Writing the control byte with enable (bit 0) and start (bit 1) both at 1 starts a conversion: busy rises after that clock edge. The start bit reads 1 for the whole conversion and clears when it ends. Writing 0 to the start bit has no effect. A start write while enable stays 0 is ignored.
- R3: A conversion keeps busy high for exactly N*D system cycles. N is 25 for the first conversion after enabling and 13 for every later one. D is the division factor selected by the prescaler code (bits 7:5): codes 0..7 give 2, 2, 4, 8, 16, 32, 64 and 128.
- R4: conv_clk is 0 while idle. During a conversion it has period D and is high for D/2 of each period, which gives N*D/2 high cycles per conversion.
- R5: At the end of a conversion, result takes the adc_data value and the completion flag (bit 3) is set in the same cycle. result changes at no other time.
- R6: The completion flag clears when irq_ack is pulsed or when 1 is written to bit 3. Writing 0 to bit 3 leaves it unchanged.
- R7: irq is 1 exactly while the completion flag and the interrupt enable (bit 4) are both 1.
- R8: The channel select (source bits 3:0) is copied to conv_ch when a conversion starts. A channel write during a conversion is held back: the source register and conv_ch keep their old values until the conversion ends, and then the new channel appears in the source register.
- R9: Writing enable to 0 during a conversion leaves enable reading 1 until that conversion ends, and then it reads 0. The next conversion after enabling again is a 25-clock initializing conversion.
- R10: With auto-trigger (bit 2) at 1 and free-running (source bit 4) at 0, a rising edge on trig_in starts a conversion while idle. An edge during a conversion is ignored, and a level held high does not restart the converter.
- R11: With auto-trigger and free-running both at 1, a start-bit write begins the first conversion. Each later conversion starts one idle cycle after the previous one ends. Clearing auto-trigger stops the sequence after the current conversion.
- R12: A prescaler code written during a conversion reads back at once but does not change that conversion's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| src_we | input | 1 | Source register write strobe |
| src_wdata | input | 5 | Source write data: bit 4 free-running, bits 3:0 channel |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the completion flag |
| trig_in | input | 1 | External trigger, synchronous to clk |
| adc_data | input | 10 | Sample from the analog converter |
| ctl_rdata | output | 8 | Control byte read value |
| src_rdata | output | 5 | Source register read value |
| busy | output | 1 | Conversion in progress |
| conv_clk | output | 1 | Divided conversion clock |
| conv_ch | output | 4 | Channel latched for the current conversion |
| result | output | 10 | Last conversion result |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The checker watches several invariants on every cycle. The start bit and the enable bit stay at 1 while busy. The flag is set on the cycle busy falls, and result holds at all other times. The interrupt request never appears without both the flag and the enable. The conversion clock stays low while idle, and the latched channel holds steady during a conversion. Exact durations for each prescaler code, the longer initializing conversion, deferred writes that appear only after the boundary, trigger edges that are ignored during a conversion, and the one-cycle gap between free-running conversions can only be shown by the bench's directed and randomized scenarios.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the conversion sequencer.
// Assumes an 8-bit control byte with a 3-bit prescaler code in its top bits.
package adc_seq_pkg;
    localparam int PS_W  = 3;
    localparam int B_EN  = 0;
    localparam int B_SC  = 1;
    localparam int B_ATE = 2;
    localparam int B_FLG = 3;
    localparam int B_IE  = 4;
    localparam int B_PS  = 5;
    localparam int CTL_W = B_PS + PS_W;

    typedef enum logic {PH_IDLE, PH_CONV} phase_e;

    // Power-of-two exponent of the divider; codes 0 and 1 both divide by 2.
    function automatic logic [PS_W-1:0] div_shift(input logic [PS_W-1:0] code);
        return (code == '0) ? PS_W'(1) : code;
    endfunction
endpackage

// File: rtl/adc_clkdiv.sv
`timescale 1ns/1ps
// Module: conversion clock divider.
// Counts system cycles while a conversion runs and emits one tick per
// divided period, plus a square conversion clock. Holds at zero when idle,
// so every conversion starts from a fresh period.
// Assumes sel is stable during a conversion (latched upstream).
module adc_clkdiv
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 1 << PS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] sel,
    output logic            tick,
    output logic            conv_clk
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [PS_W-1:0]  sh;

    // Decode the period end and the high half of the divided clock.
    always_comb begin
        sh       = div_shift(sel);
        lim      = CNT_W'((32'd1 << sh) - 32'd1);
        tick     = run && (cnt == lim);
        conv_clk = run && cnt[sh - PS_W'(1)];
    end

    // Period counter, cleared when idle and at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/adc_conv_fsm.sv
`timescale 1ns/1ps
// Module: conversion phase sequencer.
// Runs one conversion per start pulse, counting divided-clock ticks up to
// the normal or initializing length, then captures the sample.
// Assumes start is only asserted while idle.
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int N_NORM = 13,
    parameter int N_INIT = 25,
    parameter int RES_W  = 10,
    localparam int LW    = $clog2(N_INIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             init_pending,
    input  logic [RES_W-1:0] adc_data,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    phase_e      ph;
    logic        is_init;
    logic [LW-1:0] tcnt;
    logic [LW-1:0] last;

    // Final tick of the running conversion.
    always_comb begin
        last = is_init ? LW'(N_INIT - 1) : LW'(N_NORM - 1);
        busy = (ph == PH_CONV);
        done = busy && tick && (tcnt == last);
    end

    // Phase, tick count and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            is_init <= 1'b0;
            tcnt    <= '0;
            result  <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph      <= PH_CONV;
                    tcnt    <= '0;
                    is_init <= init_pending;
                end
                PH_CONV: if (done) begin
                    ph     <= PH_IDLE;
                    result <= adc_data;
                end else if (tick) begin
                    tcnt <= tcnt + LW'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_ctl_regs.sv
`timescale 1ns/1ps
// Module: software-visible control and source registers.
// Decodes writes, defers disable and channel changes to the conversion
// boundary, detects start conditions and latches per-conversion settings.
// Assumes trig_in is already synchronous to clk.
module adc_ctl_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             src_we,
    input  logic [CH_W:0]    src_wdata,
    input  logic             irq_ack,
    input  logic             trig_in,
    input  logic             busy,
    input  logic             done,
    output logic             start,
    output logic             init_pending,
    output logic [PS_W-1:0]  ps_act,
    output logic [CH_W-1:0]  conv_ch,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [CH_W:0]    src_rdata,
    output logic             irq
);
    logic            en, off_pend, sc, ate, flg, ie, free;
    logic [PS_W-1:0] ps;
    logic [CH_W-1:0] ch_sel, ch_pend_val;
    logic            ch_pend, init_done, fr_run, trig_q;
    logic            wr_en_bit, defer_off, en_eff, ate_nxt;
    logic            sw_start, trig_start, fr_start, end_off;
    logic [CH_W-1:0] ch_nxt;
    logic [PS_W-1:0] ps_nxt;

    // Start decision and next-value helpers.
    always_comb begin
        wr_en_bit  = ctl_wdata[B_EN];
        defer_off  = ctl_we && busy && !wr_en_bit;
        en_eff     = (ctl_we && !busy) ? wr_en_bit : en;
        ate_nxt    = ctl_we ? ctl_wdata[B_ATE] : ate;
        ps_nxt     = ctl_we ? ctl_wdata[B_PS +: PS_W] : ps;
        ch_nxt     = (src_we && !busy) ? src_wdata[CH_W-1:0] : ch_sel;
        sw_start   = ctl_we && ctl_wdata[B_SC] && en_eff;
        trig_start = en && ate && !free && trig_in && !trig_q;
        fr_start   = en && ate && free && fr_run;
        start      = !busy && (sw_start || trig_start || fr_start);
        end_off    = done && ((off_pend && !(ctl_we && wr_en_bit)) || defer_off);
        init_pending = !init_done;
        irq        = flg && ie;
    end

    // Enable bit with deferred disable and initialization tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            off_pend  <= 1'b0;
            init_done <= 1'b0;
        end else begin
            if (ctl_we) begin
                if (defer_off) begin
                    off_pend <= 1'b1;
                end else begin
                    en       <= wr_en_bit;
                    off_pend <= 1'b0;
                    if (!wr_en_bit)
                        init_done <= 1'b0;
                end
            end
            if (done)
                init_done <= 1'b1;
            if (end_off) begin
                en        <= 1'b0;
                off_pend  <= 1'b0;
                init_done <= 1'b0;
            end
        end
    end

    // Start bit: set by any start, cleared by hardware at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sc <= 1'b0;
        else if (start)
            sc <= 1'b1;
        else if (done)
            sc <= 1'b0;
    end

    // Completion flag: set at the end, cleared by acknowledge or write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flg <= 1'b0;
        else if (done)
            flg <= 1'b1;
        else if (irq_ack || (ctl_we && ctl_wdata[B_FLG]))
            flg <= 1'b0;
    end

    // Plain control fields taking effect immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ate  <= 1'b0;
            ie   <= 1'b0;
            ps   <= '0;
            free <= 1'b0;
        end else begin
            if (ctl_we) begin
                ate <= ctl_wdata[B_ATE];
                ie  <= ctl_wdata[B_IE];
                ps  <= ctl_wdata[B_PS +: PS_W];
            end
            if (src_we)
                free <= src_wdata[CH_W];
        end
    end

    // Channel select with a shadow held back until the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_sel      <= '0;
            ch_pend     <= 1'b0;
            ch_pend_val <= '0;
        end else begin
            if (src_we) begin
                if (busy) begin
                    ch_pend_val <= src_wdata[CH_W-1:0];
                    ch_pend     <= 1'b1;
                end else begin
                    ch_sel <= src_wdata[CH_W-1:0];
                end
            end
            if (done && (ch_pend || src_we)) begin
                ch_sel  <= src_we ? src_wdata[CH_W-1:0] : ch_pend_val;
                ch_pend <= 1'b0;
            end
        end
    end

    // Per-conversion settings latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_ch <= '0;
            ps_act  <= '0;
        end else if (start) begin
            conv_ch <= ch_nxt;
            ps_act  <= ps_nxt;
        end
    end

    // Free-running arm and trigger edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_run <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_in;
            if (start)
                fr_run <= ate_nxt && free;
            else if (!(en && ate && free))
                fr_run <= 1'b0;
        end
    end

    // Read views of both registers.
    always_comb begin
        ctl_rdata                  = '0;
        ctl_rdata[B_EN]            = en;
        ctl_rdata[B_SC]            = sc;
        ctl_rdata[B_ATE]           = ate;
        ctl_rdata[B_FLG]           = flg;
        ctl_rdata[B_IE]            = ie;
        ctl_rdata[B_PS +: PS_W]    = ps;
        src_rdata                  = {free, ch_sel};
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Module: top of the conversion control sequencer.
// Joins the register block, the clock divider and the phase sequencer.
// Assumes the analog converter presents a valid sample on adc_data at the
// end of each conversion window.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CH_W   = 4,
    parameter int N_NORM = 13,
    parameter int N_INIT = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             src_we,
    input  logic [CH_W:0]    src_wdata,
    input  logic             irq_ack,
    input  logic             trig_in,
    input  logic [RES_W-1:0] adc_data,
    output logic [7:0]       ctl_rdata,
    output logic [CH_W:0]    src_rdata,
    output logic             busy,
    output logic             conv_clk,
    output logic [CH_W-1:0]  conv_ch,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    logic            start, done, tick, init_pending;
    logic [PS_W-1:0] ps_act;

    adc_ctl_regs #(.CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .src_we(src_we), .src_wdata(src_wdata),
        .irq_ack(irq_ack), .trig_in(trig_in),
        .busy(busy), .done(done),
        .start(start), .init_pending(init_pending), .ps_act(ps_act),
        .conv_ch(conv_ch), .ctl_rdata(ctl_rdata), .src_rdata(src_rdata),
        .irq(irq)
    );

    adc_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .sel(ps_act),
        .tick(tick), .conv_clk(conv_clk)
    );

    adc_conv_fsm #(.N_NORM(N_NORM), .N_INIT(N_INIT), .RES_W(RES_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .init_pending(init_pending), .adc_data(adc_data),
        .busy(busy), .done(done), .result(result)
    );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
// Module: protocol checker bound onto the sequencer top.
// Observes only top-level ports.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctl_rdata,
    input logic             busy,
    input logic             conv_clk,
    input logic [CH_W-1:0]  conv_ch,
    input logic [RES_W-1:0] result,
    input logic             irq
);
    p_start_bit_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_rdata[B_SC]);
    p_clk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_clk);
    p_flag_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ctl_rdata[B_FLG]);
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_rdata[B_FLG] && ctl_rdata[B_IE]));
    p_ch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(conv_ch));
    p_en_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_rdata[B_EN]);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .busy(busy),
    .conv_clk(conv_clk), .conv_ch(conv_ch), .result(result), .irq(irq)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random conversions.
module sim_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       src_we = 1'b0;
    logic [4:0] src_wdata = '0;
    logic       irq_ack = 1'b0;
    logic       trig_in = 1'b0;
    logic [9:0] adc_data = '0;
    logic [7:0] ctl_rdata;
    logic [4:0] src_rdata;
    logic       busy, conv_clk, irq;
    logic [3:0] conv_ch;
    logic [9:0] result;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] mid_ctl;
    logic [4:0] mid_src;
    logic [3:0] mid_ch;
    int len, hi;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .src_we(src_we), .src_wdata(src_wdata), .irq_ack(irq_ack),
        .trig_in(trig_in), .adc_data(adc_data), .ctl_rdata(ctl_rdata),
        .src_rdata(src_rdata), .busy(busy), .conv_clk(conv_clk),
        .conv_ch(conv_ch), .result(result), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] ctl(input bit en, input bit sc, input bit ate,
                                       input bit flg, input bit ie, input int ps);
        return {ps[2:0], ie, flg, ate, sc, en};
    endfunction

    function automatic int exp_div(input int ps);
        return (ps == 0) ? 2 : (1 << ps);
    endfunction

    function automatic int exp_len(input bit first, input int ps);
        return (first ? 25 : 13) * exp_div(ps);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_src(input logic [4:0] v);
        src_wdata = v; src_we = 1'b1;
        @(negedge clk);
        src_we = 1'b0;
    endtask

    // Runs out the current conversion; optional stimulus at cycle mid_at.
    task automatic conv(input int mid_at, input int kind, input logic [7:0] mv,
                        output int n, output int h);
        n = 0; h = 0;
        while (busy === 1'b1 && n < 20000) begin
            if (conv_clk === 1'b1) h++;
            if (n == mid_at) begin
                if (kind == 1) begin ctl_wdata = mv; ctl_we = 1'b1; end
                else if (kind == 2) begin src_wdata = mv[4:0]; src_we = 1'b1; end
                else if (kind == 3) trig_in = mv[0];
            end else begin
                ctl_we = 1'b0; src_we = 1'b0;
            end
            if (n == mid_at + 2) begin
                mid_ctl = ctl_rdata; mid_src = src_rdata; mid_ch = conv_ch;
            end
            n++;
            @(negedge clk);
        end
        ctl_we = 1'b0; src_we = 1'b0;
    endtask

    initial begin
        #(64'd2_000_000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctl_rdata == 8'h00, "R1", int'(ctl_rdata), 0);
        chk(src_rdata == 5'h00, "R1", int'(src_rdata), 0);
        chk(busy == 0 && conv_clk == 0 && irq == 0, "R1", int'({busy, conv_clk, irq}), 0);
        chk(result == 10'd0, "R1", int'(result), 0);

        // First conversion after enable: initializing length, channel latch
        wr_src(5'd5);
        adc_data = 10'h2A5;
        wr_ctl(ctl(1, 1, 0, 0, 0, 0));
        chk(busy == 1'b1, "R2", int'(busy), 1);
        chk(conv_ch == 4'd5, "R8", int'(conv_ch), 5);
        conv(-100, 0, 8'h00, len, hi);
        chk(len == exp_len(1, 0), "R3", len, exp_len(1, 0));
        chk(hi == exp_len(1, 0) / 2, "R4", hi, exp_len(1, 0) / 2);
        chk(result == 10'h2A5, "R5", int'(result), 'h2A5);
        chk(ctl_rdata[3] == 1'b1, "R5", int'(ctl_rdata[3]), 1);
        chk(ctl_rdata[1] == 1'b0, "R2", int'(ctl_rdata[1]), 0);
        chk(irq == 1'b0, "R7", int'(irq), 0);
        chk(conv_clk == 1'b0, "R4", int'(conv_clk), 0);

        // Normal length at code 3, interrupt enabled, flag kept by write of 0
        adc_data = 10'h133;
        wr_ctl(ctl(1, 1, 0, 0, 1, 3));
        chk(ctl_rdata[3] == 1'b1, "R6", int'(ctl_rdata[3]), 1);
        chk(irq == 1'b1, "R7", int'(irq), 1);
        conv(-100, 0, 8'h00, len, hi);
        chk(len == exp_len(0, 3), "R3", len, exp_len(0, 3));
        chk(hi == exp_len(0, 3) / 2, "R4", hi, exp_len(0, 3) / 2);
        chk(result == 10'h133, "R5", int'(result), 'h133);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(ctl_rdata[3] == 1'b0, "R6", int'(ctl_rdata[3]), 0);
        chk(irq == 1'b0, "R7", int'(irq), 0);

        // Flag cleared by write-one; start bit written 0 starts nothing
        wr_ctl(ctl(1, 1, 0, 0, 1, 1));
        conv(-100, 0, 8'h00, len, hi);
        chk(irq == 1'b1, "R7", int'(irq), 1);
        wr_ctl(ctl(1, 0, 0, 1, 1, 1));
        chk(ctl_rdata[3] == 1'b0, "R6", int'(ctl_rdata[3]), 0);
        chk(busy == 1'b0, "R2", int'(busy), 0);

        // Start ignored while disabled
        wr_ctl(ctl(0, 0, 0, 0, 0, 0));
        wr_ctl(ctl(0, 1, 0, 0, 0, 0));
        chk(busy == 1'b0 && ctl_rdata[1] == 1'b0, "R2", int'({busy, ctl_rdata[1]}), 0);

        // Re-enabling brings back the initializing conversion
        wr_ctl(ctl(1, 1, 0, 0, 0, 1));
        conv(-100, 0, 8'h00, len, hi);
        chk(len == exp_len(1, 1), "R3", len, exp_len(1, 1));

        // Channel change during a conversion is held back
        wr_ctl(ctl(1, 1, 0, 0, 0, 2));
        conv(5, 2, 8'h09, len, hi);
        chk(mid_src[3:0] == 4'd5, "R8", int'(mid_src[3:0]), 5);
        chk(mid_ch == 4'd5, "R8", int'(mid_ch), 5);
        chk(src_rdata[3:0] == 4'd9, "R8", int'(src_rdata[3:0]), 9);
        chk(len == exp_len(0, 2), "R3", len, exp_len(0, 2));
        wr_ctl(ctl(1, 1, 0, 0, 0, 2));
        chk(conv_ch == 4'd9, "R8", int'(conv_ch), 9);
        conv(-100, 0, 8'h00, len, hi);

        // Start-bit zero and prescaler change written mid-conversion
        wr_ctl(ctl(1, 1, 0, 0, 0, 2));
        conv(4, 1, ctl(1, 0, 0, 0, 0, 5), len, hi);
        chk(mid_ctl[1] == 1'b1, "R2", int'(mid_ctl[1]), 1);
        chk(mid_ctl[7:5] == 3'd5, "R12", int'(mid_ctl[7:5]), 5);
        chk(len == exp_len(0, 2), "R12", len, exp_len(0, 2));

        // Deferred disable
        wr_ctl(ctl(1, 1, 0, 0, 0, 1));
        conv(3, 1, ctl(0, 0, 0, 0, 0, 1), len, hi);
        chk(mid_ctl[0] == 1'b1, "R9", int'(mid_ctl[0]), 1);
        chk(len == exp_len(0, 1), "R9", len, exp_len(0, 1));
        chk(ctl_rdata[0] == 1'b0, "R9", int'(ctl_rdata[0]), 0);
        wr_ctl(ctl(1, 1, 0, 0, 0, 1));
        conv(-100, 0, 8'h00, len, hi);
        chk(len == exp_len(1, 1), "R9", len, exp_len(1, 1));

        // Auto trigger on rising edge
        wr_src(5'd5);
        wr_ctl(ctl(1, 0, 1, 0, 0, 1));
        chk(busy == 1'b0, "R10", int'(busy), 0);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(busy == 1'b1, "R10", int'(busy), 1);
        conv(6, 3, 8'h01, len, hi);
        chk(len == exp_len(0, 1), "R10", len, exp_len(0, 1));
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R10", int'(busy), 0);
        trig_in = 1'b0;
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R10", int'(busy), 1);
        trig_in = 1'b0;
        conv(-100, 0, 8'h00, len, hi);

        // Free-running sequence
        wr_src(5'h13);
        chk(busy == 1'b0, "R11", int'(busy), 0);
        wr_ctl(ctl(1, 1, 1, 0, 0, 1));
        conv(-100, 0, 8'h00, len, hi);
        chk(len == exp_len(0, 1), "R11", len, exp_len(0, 1));
        chk(busy == 1'b0, "R11", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R11", int'(busy), 1);
        conv(3, 1, ctl(1, 0, 0, 0, 0, 1), len, hi);
        chk(len == exp_len(0, 1), "R11", len, exp_len(0, 1));
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R11", int'(busy), 0);
        wr_src(5'd0);

        // Seeded random conversions
        for (int i = 0; i < 12; i++) begin
            int ps, ch, d;
            ps = int'($urandom_range(0, 4));
            ch = int'($urandom_range(0, 15));
            d  = int'($urandom_range(0, 1023));
            adc_data = d[9:0];
            wr_src(ch[4:0]);
            wr_ctl(ctl(1, 1, 0, 0, 0, ps));
            chk(conv_ch == ch[3:0], "R8", int'(conv_ch), ch);
            conv(-100, 0, 8'h00, len, hi);
            chk(len == exp_len(0, ps), "R3", len, exp_len(0, ps));
            chk(hi == exp_len(0, ps) / 2, "R4", hi, exp_len(0, ps) / 2);
            chk(result == d[9:0], "R5", int'(result), d);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule